// File: doc/BRIEF.md
# SD Host Status and Interrupt Controller

This block keeps the event and error status of an SD card host controller and turns it into one level-sensitive interrupt line. The command engine, the data path and the FIFO each report events as single-cycle pulses. Each pulse sets its own sticky status bit. Software clears a sticky bit by writing a 1 to its position. The FIFO also supplies a live data-ready level. This level is shown in the status word as it is and is never latched.

The block also holds the host configuration word. Four of its bits enable interrupt sources: busy-done, block-done, SDIO and data-ready. The other defined bits are plain storage and are read back unchanged. The interrupt output goes high when an enabled source is active. The error bits never raise the interrupt. Instead they drive a separate error-summary output. Software reaches both words through a simple write-enable and data interface, and reads them continuously on the read ports.

Top module: `sdh_irq_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it falls, all sticky status bits and all configuration bits read 0, and the interrupt output is low if data-ready is low.
- R2: A pulse on set_pulse[k] sets status bit k+3 at the next clock edge. The bits are mapped as follows: 10 busy-done, 9 block-done, 8 SDIO, 7 data-line timeout, 6 command timeout, 5 CRC16 error, 4 CRC7 error, 3 FIFO error. A set bit stays set until it is cleared.
- R3: A status write with a 1 at a position in 10..3 clears that bit at the next edge. A 0 at a position leaves that bit unchanged.
- R4: When a set pulse and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R5: Status bit 0 shows the live data_ready input in the same cycle. Status bits 2..1 always read 0. Status writes have no effect on bits 2..0.
- R6: A configuration write stores bits 10, 8, 5, 4, 3, 2, 1 and 0 and reads them back unchanged. Bits 9, 7 and 6 are discarded and read 0. Without a write, the configuration word holds its value.
- R7: irq is the OR of four terms: busy-done with enable bit 10, block-done with enable bit 8, SDIO with enable bit 5, and data_ready with enable bit 4.
- R8: err_any is high while any of status bits 7..3 is set. These error bits never raise irq.
- R9: data_ready raises irq in the same cycle, and only while enable bit 4 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_pulse | input | 8 | Event pulses; bit k sets status bit k+3 |
| data_ready | input | 1 | Live FIFO data-ready level |
| stat_we | input | 1 | Status write strobe (write-1-to-clear) |
| stat_wdata | input | 11 | Status write data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 11 | Configuration write data |
| status_q | output | 11 | Status word |
| cfg_q | output | 11 | Configuration word |
| irq | output | 1 | Level interrupt |
| err_any | output | 1 | Error-group summary |

## Verification
Each of the eight event inputs is pulsed alone with three enables set. This separates the three sources that may interrupt from the five error bits that may only drive err_any, and it shows the bit mapping. After each pulse, the bench writes the inverse mask and then the exact mask. This separates a write of 0 from a write of 1. The bench sweeps all 16 enable patterns against all 16 patterns of the busy, block, SDIO and data-ready sources to pin down the interrupt equation. A simultaneous set and clear over all bits, together with full-ones and reserved-only configuration writes, covers the priority rule and the storage mask.

// File: rtl/sdh_pkg.sv
package sdh_pkg;
    localparam int STAT_W  = 11;
    localparam int CFG_W   = 11;
    localparam int EVT_LO  = 3;
    localparam int EVT_N   = STAT_W - EVT_LO;

    localparam int ST_BUSY  = 10;
    localparam int ST_BLOCK = 9;
    localparam int ST_SDIO  = 8;
    localparam int ST_DATA  = 0;

    localparam int CF_BUSY_EN  = 10;
    localparam int CF_BLOCK_EN = 8;
    localparam int CF_SDIO_EN  = 5;
    localparam int CF_DATA_EN  = 4;

    localparam logic [STAT_W-1:0] ERR_MASK = 11'h0F8;
    localparam logic [CFG_W-1:0]  CFG_KEEP = 11'h53F;

    typedef struct packed {
        logic busy;
        logic block;
        logic sdio;
        logic data;
    } irq_src_t;

    function automatic irq_src_t pick_src(input logic [STAT_W-1:0] st);
        irq_src_t s;
        s.busy  = st[ST_BUSY];
        s.block = st[ST_BLOCK];
        s.sdio  = st[ST_SDIO];
        s.data  = st[ST_DATA];
        return s;
    endfunction

    function automatic irq_src_t pick_en(input logic [CFG_W-1:0] cf);
        irq_src_t e;
        e.busy  = cf[CF_BUSY_EN];
        e.block = cf[CF_BLOCK_EN];
        e.sdio  = cf[CF_SDIO_EN];
        e.data  = cf[CF_DATA_EN];
        return e;
    endfunction
endpackage

// File: rtl/sdh_sticky_bank.sv
module sdh_sticky_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)           bit_q <= 1'b0;
            else if (set_i[i]) bit_q <= 1'b1;
            else if (clr_i[i]) bit_q <= 1'b0;
        end
        assign q_o[i] = bit_q;

        p_set_r2: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> q_o[i]);
        p_hold_r2: assert property (@(posedge clk) disable iff (rst)
            (q_o[i] && !clr_i[i]) |=> q_o[i]);
        p_clr_r3: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && !set_i[i]) |=> !q_o[i]);
        p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && set_i[i]) |=> q_o[i]);
    end

    p_reset_r1: assert property (@(posedge clk) rst |=> (q_o == '0));
endmodule

// File: rtl/sdh_cfg_reg.sv
module sdh_cfg_reg #(
    parameter int             W    = 11,
    parameter logic [W-1:0]   KEEP = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] cfg_r;

    always_ff @(posedge clk) begin
        if (rst)       cfg_r <= '0;
        else if (we_i) cfg_r <= wdata_i & KEEP;
    end
    assign q_o = cfg_r;

    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> $stable(q_o));
endmodule

// File: rtl/sdh_irq_combine.sv
module sdh_irq_combine
    import sdh_pkg::*;
(
    input  logic [STAT_W-1:0] status_i,
    input  logic [CFG_W-1:0]  cfg_i,
    output logic              irq_o,
    output logic              err_o
);
    irq_src_t src, en;

    always_comb begin
        src   = pick_src(status_i);
        en    = pick_en(cfg_i);
        irq_o = |(src & en);
        err_o = |(status_i & ERR_MASK);
    end
endmodule

// File: rtl/sdh_irq_ctrl.sv
module sdh_irq_ctrl
    import sdh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [EVT_N-1:0]  set_pulse,
    input  logic              data_ready,
    input  logic              stat_we,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [STAT_W-1:0] status_q,
    output logic [CFG_W-1:0]  cfg_q,
    output logic              irq,
    output logic              err_any
);
    logic [EVT_N-1:0] clr_vec;
    logic [EVT_N-1:0] sticky;

    assign clr_vec = stat_we ? stat_wdata[STAT_W-1:EVT_LO] : '0;

    sdh_sticky_bank #(.N(EVT_N)) u_sticky (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_pulse),
        .clr_i (clr_vec),
        .q_o   (sticky)
    );

    sdh_cfg_reg #(.W(CFG_W), .KEEP(CFG_KEEP)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we_i    (cfg_we),
        .wdata_i (cfg_wdata),
        .q_o     (cfg_q)
    );

    assign status_q = {sticky, {(EVT_LO-1){1'b0}}, data_ready};

    sdh_irq_combine u_comb (
        .status_i (status_q),
        .cfg_i    (cfg_q),
        .irq_o    (irq),
        .err_o    (err_any)
    );

    p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
        ((cfg_q & 11'h530) == '0) |-> !irq);
    p_err_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (err_any && !stat_we) |=> err_any);
    p_err_no_irq_r8: assert property (@(posedge clk) disable iff (rst)
        ((status_q & 11'h701) == '0) |-> !irq);
    p_data_gate_r9: assert property (@(posedge clk) disable iff (rst)
        (data_ready && cfg_q[CF_DATA_EN]) |-> irq);
endmodule

// File: tb/sim_sdh_irq_ctrl.sv
module sim_sdh_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  set_pulse;
    logic        data_ready;
    logic        stat_we;
    logic [10:0] stat_wdata;
    logic        cfg_we;
    logic [10:0] cfg_wdata;
    logic [10:0] status_q;
    logic [10:0] cfg_q;
    logic        irq;
    logic        err_any;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdh_irq_ctrl u0 (
        .clk(clk), .rst(rst), .set_pulse(set_pulse), .data_ready(data_ready),
        .stat_we(stat_we), .stat_wdata(stat_wdata), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .status_q(status_q), .cfg_q(cfg_q),
        .irq(irq), .err_any(err_any)
    );

    task automatic chk(input string req, input logic [10:0] act, input logic [10:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // inputs set before this are captured at the next rising edge
    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        set_pulse = '0; stat_we = 0; cfg_we = 0;
    endtask

    task automatic wr_stat(input logic [10:0] d);
        stat_we = 1; stat_wdata = d; cycle();
    endtask

    task automatic wr_cfg(input logic [10:0] d);
        cfg_we = 1; cfg_wdata = d; cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; set_pulse = '0; data_ready = 0; stat_we = 0; stat_wdata = '0;
        cfg_we = 0; cfg_wdata = '0;
        @(negedge clk);
        set_pulse = 8'hFF; cfg_we = 1; cfg_wdata = 11'h7FF;
        cycle(); cycle();
        rst = 0;
        chk("R1 status", status_q, 11'h000);
        chk("R1 cfg", cfg_q, 11'h000);
        chk("R1 irq", {10'b0, irq}, 11'h0);

        // R2/R3/R7/R8: each event alone, busy/block/sdio enabled
        wr_cfg(11'h520);
        for (int k = 0; k < 8; k++) begin
            logic [10:0] m;
            m = 11'(1) << (k + 3);
            set_pulse = 8'(1) << k; cycle();
            chk("R2 set", status_q, m);
            cycle();
            chk("R2 sticky", status_q, m);
            chk("R8 err_any", {10'b0, err_any}, {10'b0, (k <= 4)});
            chk("R7 R8 irq", {10'b0, irq}, {10'b0, (k >= 5)});
            wr_stat(~m);
            chk("R3 zero write keeps", status_q, m);
            wr_stat(m);
            chk("R3 clear", status_q, 11'h000);
            chk("R8 err cleared", {10'b0, err_any}, 11'h0);
        end

        // R4: set and clear collide
        set_pulse = 8'hFF; stat_we = 1; stat_wdata = 11'h7F8; cycle();
        chk("R4 set wins", status_q, 11'h7F8);
        wr_stat(11'h7FF);
        chk("R4 cleared after", status_q, 11'h000);

        // R5: data flag live, low bits unaffected
        wr_stat(11'h007);
        chk("R5 low bits write", status_q, 11'h000);
        data_ready = 1; #1;
        chk("R5 data live", status_q, 11'h001);
        data_ready = 0; #1;
        chk("R5 data drop", status_q, 11'h000);

        // R6: cfg storage mask
        wr_cfg(11'h7FF);
        chk("R6 all ones", cfg_q, 11'h53F);
        wr_cfg(11'h2C0);
        chk("R6 reserved only", cfg_q, 11'h000);
        wr_cfg(11'h00A);
        cycle();
        chk("R6 keep", cfg_q, 11'h00A);

        // R9: data enable gating
        data_ready = 1; #1;
        chk("R9 no enable", {10'b0, irq}, 11'h0);
        wr_cfg(11'h010);
        chk("R9 enabled", {10'b0, irq}, 11'h1);
        data_ready = 0; #1;
        chk("R9 level drop", {10'b0, irq}, 11'h0);

        // R7: exhaustive enables x sources (busy,block,sdio,data)
        for (int en = 0; en < 16; en++) begin
            for (int src = 0; src < 16; src++) begin
                logic [10:0] cf;
                logic exp_irq;
                cf = {en[3], 1'b0, en[2], 2'b00, en[1], en[0], 4'b0000};
                wr_cfg(cf);
                set_pulse = {src[3], src[2], src[1], 5'b0};
                cycle();
                data_ready = src[0]; #1;
                exp_irq = |(en[3:0] & src[3:0]);
                chk("R7 sweep", {10'b0, irq}, {10'b0, exp_irq});
                data_ready = 0;
                wr_stat(11'h7F8);
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule